// File: doc/BRIEF.md
# Multi-Slot Cartridge Mapper

This block sits on the cartridge side of a handheld console bus. Behind it are one large flash device and one battery-backed SRAM. The flash is divided into equal 512 KiB game slots and a system region above them. The SRAM is divided into 32 KiB save slots. After reset, the console reads a boot menu from the system region. The menu code can switch the lower 16 KiB window to a directory page that lists the stored games and saves. It then picks a game slot and a save slot and starts the game.

Configuration lives at three addresses, 0x1100, 0x3100 and 0x4100, which fall inside the ordinary bank-control ranges. A slot byte holds the game slot in its low nibble and the save slot in its high nibble. A start code written twice in a row to 0x3100 commits the choice. The same sequence can instead hand the bus to a physical cartridge plugged into the unit. Once the start is committed, the configuration addresses are locked until reset. From then on the console sees a conventional banked layout: a 9-bit ROM bank register, a RAM bank register and a RAM enable key.

All outputs are registered. An address presented at one clock edge is translated at the next edge.

Top module: `cart_mapper`

## Requirements
- R1: After reset, the mapper is in boot mode. cart_pass, flash_ce and sram_ce are 0, RAM access is disabled, the ROM bank is 1 and the RAM bank is 0.
- R2: In boot mode, a ROM read at console address A (0x0000–0x7FFF) drives flash_addr = 0x800000 + (A mod 0x2800). The system region starts above the 16 game slots.
- R3: A write of 0x0A to 0x0000–0x1FFF enables SRAM access, and any other value disables it. sram_ce is 1 only when ram_cs is high, access is enabled and the mapper is not in pass-through mode.
- R4: In boot mode, when the slot byte is 0x80, the view byte (0x4100) is 0x90 and SRAM access is enabled, reads below 0x4000 map to 0x808000 + A[13:0]. Reads from 0x4000 upward stay on the boot image. Changing the slot byte returns the lower window to the boot image.
- R5: A single 0xDB write to 0x3100 changes nothing. A second consecutive 0xDB write starts game mode with game slot = slot byte [3:0] and save slot = slot byte [7:4].
- R6: If the second 0x3100 write differs from the armed code, that write becomes the new armed code and nothing starts. A matched pair of any code other than 0xDB, or other than 0xC0 with slot byte 0x08, disarms without starting.
- R7: Slot byte 0x08 followed by two 0xC0 writes to 0x3100 enters pass-through. In pass-through, cart_pass is 1 and flash_ce and sram_ce stay 0.
- R8: In game mode, reads at 0x0000–0x3FFF map to slot×0x80000 + A[13:0]. Reads at 0x4000–0x7FFF map to slot×0x80000 + bank×0x4000 + A[13:0], computed modulo 0x800000. Bank 0 is allowed in the upper window.
- R9: A write to 0x2000–0x2FFF sets ROM bank bits [7:0]. A write to 0x3000–0x3FFF sets ROM bank bit 8 from data bit 0.
- R10: sram_addr = save slot×0x8000 + RAM bank×0x2000 + A[12:0]. Writes to 0x4000–0x5FFF set the RAM bank from data bits [1:0].
- R11: After a start, writes to 0x1100, 0x3100 and 0x4100 act only as RAM-enable, bank bit 8 and RAM-bank writes. The slot selection is unchanged until reset.
- R12: flash_ce follows rom_cs one cycle later, except in pass-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Console address |
| bus_din | input | 8 | Console write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| rom_cs | input | 1 | Console ROM-area select |
| ram_cs | input | 1 | Console external-RAM select |
| flash_addr | output | 24 | Flash byte address (bit 23 selects the system region) |
| flash_ce | output | 1 | Flash chip enable |
| sram_addr | output | 19 | SRAM byte address |
| sram_ce | output | 1 | SRAM chip enable |
| cart_pass | output | 1 | Route the bus to the physical cartridge |

## Verification
The bench reads the boot image on both sides of each 0x2800 boundary and at the top of the window. A design that used a power-of-two mirror, or that missed the third wrap, returns the wrong flash offset there.

It arms the start register with one write, with mismatched pairs and with an invalid matched pair, and checks that boot mode survives each case. A single-write or any-pair design would start the game too early.

After a start it writes 0x1100, 0x3100 and 0x4100 again and checks three things: the game slot stays put, bank bit 8 moves the upper window by 4 MiB, and the RAM bank follows. An unlocked design would jump slots.

Bank 0 in the upper window is checked against the slot base, because standard remapping of 0 to 1 would give the wrong address. Pass-through is checked with both chip selects active, to catch enables that leak.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  typedef enum logic [1:0] {
    MODE_BOOT = 2'd0,
    MODE_GAME = 2'd1,
    MODE_PASS = 2'd2
  } run_mode_e;

  localparam logic [15:0] ADR_SLOT   = 16'h1100;
  localparam logic [15:0] ADR_START  = 16'h3100;
  localparam logic [15:0] ADR_VIEW   = 16'h4100;

  localparam logic [7:0]  RAM_KEY    = 8'h0A;
  localparam logic [7:0]  CODE_GAME  = 8'hDB;
  localparam logic [7:0]  CODE_PASS  = 8'hC0;
  localparam logic [7:0]  SLOT_PASS  = 8'h08;
  localparam logic [7:0]  SLOT_DIR   = 8'h80;
  localparam logic [7:0]  VIEW_DIR   = 8'h90;
endpackage

// File: rtl/cmap_cfg.sv
module cmap_cfg
  import cmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [7:0]  din,
  output run_mode_e   mode,
  output logic [7:0]  slot_sel,
  output logic        dir_sel,
  output logic        cfg_claim
);
  run_mode_e  mode_q;
  logic [7:0] slot_q;
  logic [7:0] view_q;
  logic [7:0] arm_code_q;
  logic       armed_q;
  logic       locked;
  logic       hit_slot, hit_start, hit_view;

  assign locked    = (mode_q != MODE_BOOT);
  assign hit_slot  = !locked && (addr == ADR_SLOT);
  assign hit_start = !locked && (addr == ADR_START);
  assign hit_view  = !locked && (addr == ADR_VIEW);
  assign cfg_claim = hit_slot || hit_start || hit_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_BOOT;
      slot_q     <= 8'h00;
      view_q     <= 8'h00;
      arm_code_q <= 8'h00;
      armed_q    <= 1'b0;
    end else if (wr_en) begin
      if (hit_slot) slot_q <= din;
      if (hit_view) view_q <= din;
      if (hit_start) begin
        if (armed_q && (din == arm_code_q)) begin
          armed_q <= 1'b0;
          if (din == CODE_GAME)
            mode_q <= MODE_GAME;
          else if ((din == CODE_PASS) && (slot_q == SLOT_PASS))
            mode_q <= MODE_PASS;
        end else begin
          armed_q    <= 1'b1;
          arm_code_q <= din;
        end
      end
    end
  end

  assign mode     = mode_q;
  assign slot_sel = slot_q;
  assign dir_sel  = (slot_q == SLOT_DIR) && (view_q == VIEW_DIR);

  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    ((mode_q != MODE_BOOT) && ($past(mode_q) == MODE_BOOT)) |-> $past(armed_q)); // R5

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_BOOT) |=> ((mode_q == $past(mode_q)) && $stable(slot_q))); // R11
endmodule

// File: rtl/cmap_mbc.sv
module cmap_mbc
  import cmap_pkg::*;
#(
  parameter int ROM_BANK_BITS = 9,
  parameter int RAM_BANK_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [3:0]               addr_hi,
  input  logic [7:0]               din,
  output logic                     ram_en,
  output logic [ROM_BANK_BITS-1:0] rom_bank,
  output logic [RAM_BANK_BITS-1:0] ram_bank
);
  localparam int HI_BITS = ROM_BANK_BITS - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en   <= 1'b0;
      rom_bank <= ROM_BANK_BITS'(1);
      ram_bank <= '0;
    end else if (wr_en) begin
      case (addr_hi)
        4'h0, 4'h1: ram_en <= (din == RAM_KEY);
        4'h2:       rom_bank[7:0] <= din;
        4'h3:       rom_bank[ROM_BANK_BITS-1:8] <= din[HI_BITS-1:0];
        4'h4, 4'h5: ram_bank <= din[RAM_BANK_BITS-1:0];
        default: ;
      endcase
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rom_bank)); // R9
endmodule

// File: rtl/cmap_xlat.sv
module cmap_xlat
  import cmap_pkg::*;
#(
  parameter int ROM_SLOT_BITS  = 4,
  parameter int SRAM_SLOT_BITS = 4,
  parameter int SLOT_AW        = 19,
  parameter int SAVE_AW        = 15,
  parameter int ROM_BANK_BITS  = 9,
  parameter int RAM_BANK_BITS  = 2,
  parameter int BOOT_PERIOD    = 'h2800,
  parameter int DIR_BASE       = 'h8000,
  localparam int AREA_W        = ROM_SLOT_BITS + SLOT_AW,
  localparam int FA_W          = AREA_W + 1,
  localparam int SA_W          = SRAM_SLOT_BITS + SAVE_AW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  run_mode_e                mode,
  input  logic [7:0]               slot_sel,
  input  logic                     dir_sel,
  input  logic                     ram_en,
  input  logic [ROM_BANK_BITS-1:0] rom_bank,
  input  logic [RAM_BANK_BITS-1:0] ram_bank,
  input  logic [14:0]              addr,
  input  logic                     rom_cs,
  input  logic                     ram_cs,
  output logic [FA_W-1:0]          flash_addr,
  output logic                     flash_ce,
  output logic [SA_W-1:0]          sram_addr,
  output logic                     sram_ce,
  output logic                     cart_pass
);
  localparam int ROM_WIN_AW = 14;
  localparam int RAM_WIN_AW = 13;

  logic [ROM_SLOT_BITS-1:0]  rom_slot;
  logic [SRAM_SLOT_BITS-1:0] save_slot;
  logic [AREA_W-1:0]         game_off, sys_off, win_off;
  logic [15:0]               mirror;
  logic [FA_W-1:0]           fa_next;
  logic [SA_W-1:0]           sa_next;
  logic                      dir_active;

  assign rom_slot   = slot_sel[ROM_SLOT_BITS-1:0];
  assign save_slot  = slot_sel[4 +: SRAM_SLOT_BITS];
  assign dir_active = dir_sel && ram_en && (mode == MODE_BOOT);

  always_comb begin
    mirror   = {1'b0, addr} % 16'(BOOT_PERIOD);
    win_off  = addr[14] ? (AREA_W'(rom_bank) << ROM_WIN_AW) : '0;
    game_off = (AREA_W'(rom_slot) << SLOT_AW) + win_off
             + AREA_W'(addr[ROM_WIN_AW-1:0]);
    if (dir_active && !addr[14])
      sys_off = AREA_W'(DIR_BASE) + AREA_W'(addr[ROM_WIN_AW-1:0]);
    else
      sys_off = AREA_W'(mirror);
    fa_next = (mode == MODE_BOOT) ? {1'b1, sys_off} : {1'b0, game_off};
    sa_next = (SA_W'(save_slot) << SAVE_AW) + (SA_W'(ram_bank) << RAM_WIN_AW)
            + SA_W'(addr[RAM_WIN_AW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_addr <= '0;
      flash_ce   <= 1'b0;
      sram_addr  <= '0;
      sram_ce    <= 1'b0;
      cart_pass  <= 1'b0;
    end else begin
      flash_addr <= fa_next;
      flash_ce   <= rom_cs && (mode != MODE_PASS);
      sram_addr  <= sa_next;
      sram_ce    <= ram_cs && ram_en && (mode != MODE_PASS);
      cart_pass  <= (mode == MODE_PASS);
    end
  end

  AST_PASS_QUIET: assert property (@(posedge clk) disable iff (rst)
    cart_pass |-> (!flash_ce && !sram_ce)); // R7

  AST_SRAM_GATED: assert property (@(posedge clk) disable iff (rst)
    sram_ce |-> ($past(ram_en) && $past(ram_cs))); // R3

  AST_FLASH_FOLLOWS_CS: assert property (@(posedge clk) disable iff (rst)
    flash_ce |-> $past(rom_cs)); // R12
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cmap_pkg::*;
#(
  parameter int ROM_SLOT_BITS  = 4,
  parameter int SRAM_SLOT_BITS = 4,
  parameter int SLOT_AW        = 19,
  parameter int SAVE_AW        = 15,
  parameter int ROM_BANK_BITS  = 9,
  parameter int RAM_BANK_BITS  = 2,
  parameter int BOOT_PERIOD    = 'h2800,
  parameter int DIR_BASE       = 'h8000,
  localparam int FA_W          = ROM_SLOT_BITS + SLOT_AW + 1,
  localparam int SA_W          = SRAM_SLOT_BITS + SAVE_AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     bus_addr,
  input  logic [7:0]      bus_din,
  input  logic            bus_wr,
  input  logic            rom_cs,
  input  logic            ram_cs,
  output logic [FA_W-1:0] flash_addr,
  output logic            flash_ce,
  output logic [SA_W-1:0] sram_addr,
  output logic            sram_ce,
  output logic            cart_pass
);
  run_mode_e                mode;
  logic [7:0]               slot_sel;
  logic                     dir_sel, cfg_claim, wr_en, mbc_wr, ram_en;
  logic [ROM_BANK_BITS-1:0] rom_bank;
  logic [RAM_BANK_BITS-1:0] ram_bank;

  assign wr_en  = bus_wr && !bus_addr[15];
  assign mbc_wr = wr_en && !cfg_claim;

  cmap_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr), .din(bus_din),
    .mode(mode), .slot_sel(slot_sel), .dir_sel(dir_sel), .cfg_claim(cfg_claim)
  );

  cmap_mbc #(
    .ROM_BANK_BITS(ROM_BANK_BITS), .RAM_BANK_BITS(RAM_BANK_BITS)
  ) u_mbc (
    .clk(clk), .rst(rst), .wr_en(mbc_wr), .addr_hi(bus_addr[15:12]),
    .din(bus_din), .ram_en(ram_en), .rom_bank(rom_bank), .ram_bank(ram_bank)
  );

  cmap_xlat #(
    .ROM_SLOT_BITS(ROM_SLOT_BITS), .SRAM_SLOT_BITS(SRAM_SLOT_BITS),
    .SLOT_AW(SLOT_AW), .SAVE_AW(SAVE_AW), .ROM_BANK_BITS(ROM_BANK_BITS),
    .RAM_BANK_BITS(RAM_BANK_BITS), .BOOT_PERIOD(BOOT_PERIOD), .DIR_BASE(DIR_BASE)
  ) u_xlat (
    .clk(clk), .rst(rst), .mode(mode), .slot_sel(slot_sel), .dir_sel(dir_sel),
    .ram_en(ram_en), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .addr(bus_addr[14:0]), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .flash_addr(flash_addr), .flash_ce(flash_ce), .sram_addr(sram_addr),
    .sram_ce(sram_ce), .cart_pass(cart_pass)
  );
endmodule

// File: tb/tb_cart_mapper.sv
module tb_cart_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_din = '0;
  logic        bus_wr = 1'b0, rom_cs = 1'b0, ram_cs = 1'b0;
  logic [23:0] flash_addr;
  logic [18:0] sram_addr;
  logic        flash_ce, sram_ce, cart_pass;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_mapper dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_wr(bus_wr), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .flash_addr(flash_addr), .flash_ce(flash_ce), .sram_addr(sram_addr),
    .sram_ce(sram_ce), .cart_pass(cart_pass)
  );

  // {write, addr, data, expected flash_addr, requirement number}
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 16'h0000, 8'h00, 24'h800000, 4'd1},   // R1 boot base
    {1'b0, 16'h2800, 8'h00, 24'h800000, 4'd2},   // R2 first wrap
    {1'b0, 16'h2805, 8'h00, 24'h800005, 4'd2},
    {1'b0, 16'h7FFF, 8'h00, 24'h8007FF, 4'd2},   // R2 third wrap
    {1'b0, 16'h4123, 8'h00, 24'h801923, 4'd2},
    {1'b1, 16'h0000, 8'h0A, 24'h0,      4'd0},
    {1'b1, 16'h1100, 8'h80, 24'h0,      4'd0},
    {1'b1, 16'h4100, 8'h90, 24'h0,      4'd0},
    {1'b0, 16'h0123, 8'h00, 24'h808123, 4'd4},   // R4 directory
    {1'b0, 16'h4123, 8'h00, 24'h801923, 4'd4},
    {1'b1, 16'h1100, 8'h00, 24'h0,      4'd0},
    {1'b0, 16'h0123, 8'h00, 24'h800123, 4'd4},
    {1'b1, 16'h1100, 8'h23, 24'h0,      4'd0},
    {1'b1, 16'h3100, 8'hDB, 24'h0,      4'd0},
    {1'b0, 16'h0000, 8'h00, 24'h800000, 4'd5},   // R5 one write only
    {1'b1, 16'h3100, 8'hDB, 24'h0,      4'd0},
    {1'b0, 16'h0010, 8'h00, 24'h180010, 4'd5},
    {1'b0, 16'h4010, 8'h00, 24'h184010, 4'd8},   // R8 reset bank 1
    {1'b1, 16'h2000, 8'h00, 24'h0,      4'd0},
    {1'b0, 16'h4010, 8'h00, 24'h180010, 4'd8},   // R8 bank 0
    {1'b1, 16'h2000, 8'h05, 24'h0,      4'd0},
    {1'b0, 16'h7FFF, 8'h00, 24'h197FFF, 4'd8},
    {1'b1, 16'h3100, 8'h01, 24'h0,      4'd0},
    {1'b0, 16'h7FFF, 8'h00, 24'h597FFF, 4'd9},   // R9 bit 8
    {1'b1, 16'h1100, 8'h55, 24'h0,      4'd0},
    {1'b0, 16'h0010, 8'h00, 24'h180010, 4'd11}   // R11 slot kept
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_din = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, input logic rc, input logic mc);
    bus_addr = a; rom_cs = rc; ram_cs = mc;
    @(negedge clk);
  endtask

  task automatic idle();
    rom_cs = 1'b0; ram_cs = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "flash_ce", 32'(flash_ce), 0);
    chk("R1", "sram_ce", 32'(sram_ce), 0);
    chk("R1", "cart_pass", 32'(cart_pass), 0);
    do_rd(16'hA000, 1'b0, 1'b1);
    chk("R1", "sram_ce disabled", 32'(sram_ce), 0);
    chk("R1", "sram_addr bank0", 32'(sram_addr), 32'h00000);
    idle();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) begin
        do_wr(VEC[i][51:36], VEC[i][35:28]);
      end else begin
        do_rd(VEC[i][51:36], 1'b1, 1'b0);
        chk($sformatf("R%0d", VEC[i][3:0]), "flash_addr",
            32'(flash_addr), 32'(VEC[i][27:4]));
        chk("R12", "flash_ce", 32'(flash_ce), 1);
        idle();
      end
    end

    // R12: no rom_cs, no flash enable
    do_rd(16'h0010, 1'b0, 1'b0);
    chk("R12", "flash_ce idle", 32'(flash_ce), 0);
    // R3 disabled by the 0x55 write, R10 addressing
    do_rd(16'hA123, 1'b0, 1'b1);
    chk("R3", "sram_ce off", 32'(sram_ce), 0);
    idle();
    do_wr(16'h0000, 8'h0A);
    do_wr(16'h4000, 8'h03);
    do_rd(16'hA123, 1'b0, 1'b1);
    chk("R3", "sram_ce on", 32'(sram_ce), 1);
    chk("R10", "sram_addr", 32'(sram_addr), 32'h16123);
    idle();
    // R11: 0x4100 now a RAM bank write
    do_wr(16'h4100, 8'h01);
    do_rd(16'hA000, 1'b0, 1'b1);
    chk("R11", "sram_addr view addr", 32'(sram_addr), 32'h12000);
    idle();

    // R6: mismatched and invalid pairs
    do_reset();
    do_wr(16'h1100, 8'h01);
    do_wr(16'h3100, 8'hDB);
    do_wr(16'h3100, 8'hDA);
    do_rd(16'h0000, 1'b1, 1'b0);
    chk("R6", "mismatch stays boot", 32'(flash_addr), 32'h800000);
    idle();
    do_wr(16'h3100, 8'hDB);
    do_rd(16'h0000, 1'b1, 1'b0);
    chk("R6", "rearm stays boot", 32'(flash_addr), 32'h800000);
    idle();
    do_wr(16'h3100, 8'hDB);
    do_rd(16'h0000, 1'b1, 1'b0);
    chk("R6", "matched pair starts", 32'(flash_addr), 32'h080000);
    idle();

    do_reset();
    do_wr(16'h3100, 8'h55);
    do_wr(16'h3100, 8'h55);
    do_rd(16'h0000, 1'b1, 1'b0);
    chk("R6", "invalid pair", 32'(flash_addr), 32'h800000);
    idle();

    // R7: pass-through
    do_reset();
    do_wr(16'h0000, 8'h0A);
    do_wr(16'h1100, 8'h08);
    do_wr(16'h3100, 8'hC0);
    do_wr(16'h3100, 8'hC0);
    do_rd(16'h0150, 1'b1, 1'b1);
    chk("R7", "cart_pass", 32'(cart_pass), 1);
    chk("R7", "flash_ce", 32'(flash_ce), 0);
    chk("R7", "sram_ce", 32'(sram_ce), 0);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule